// File: doc/BRIEF.md
# Prescaler-Tap Watchdog Timer

This block guards against runaway software. A tiny two-bit counter is advanced by carry pulses taken from one of two free-running prescaler chains: a time-base chain that counts every main-clock cycle, and a watch chain that counts rising edges of a slow sub clock. The sub clock is brought into the main clock domain through a synchronizer. A source bit picks the chain, and a two-bit tap field picks which stage of that chain supplies the carry. On the fourth carry after the last clear, the block issues a reset pulse to the processor.

The block sits idle after a system reset. The first configuration write arms it, and the configuration is then frozen until the block fires. Software keeps it quiet by pulsing the clear strobe. Neither chain is ever stopped by that strobe, so the carry phase relative to a clear is arbitrary and the timeout is a window, not an exact count. A separate input restarts the time-base chain; while the main chain supplies the carries, doing so postpones the next carry and stretches the timeout. The reset pulse also disarms the block.

Top module: `wdt_tap`

## Requirements
- R1: After a system reset the block is disarmed: no reset pulse appears and the clear strobe has no effect until a configuration write.
- R2: A write while disarmed arms the block, clears the two-bit counter and latches the configuration: data bit 2 is the source (1 = main-clock time-base chain, 0 = sub-clock watch chain), bits 1:0 select tap index 0 to 3.
- R3: While armed, configuration writes change neither the source, the tap nor the counter.
- R4: With the main source and tap stage k = MAIN_TAPS[index], the reset pulse rises between 3·2^k+1 and 4·2^k main-clock cycles after the clock edge of the last clear.
- R5: With the sub source and tap stage k = SUB_TAPS[index], and a sub-clock period of P main cycles, the reset pulse rises between 3·2^k·P+1 and 4·2^k·P main-clock cycles after the last clear.
- R6: The clear strobe returns the counter to zero; clears spaced at most 3·2^k tap periods apart keep the reset from firing.
- R7: The time-base restart input zeroes the main chain; while it is pulsed more often than one tap period, the main source never times out, and after the last pulse the timeout is counted from that pulse.
- R8: The reset pulse is high for exactly RST_W consecutive main-clock cycles.
- R9: The reset pulse disarms the block; no further pulse follows, and clears are ignored, until the next configuration write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Main clock |
| rst_ni | input | 1 | Synchronous system reset, active low |
| sclk_i | input | 1 | Slow sub clock, sampled in the main domain |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 3 | Configuration data: bit 2 source, bits 1:0 tap index |
| kick_i | input | 1 | Software clear of the watchdog counter |
| tb_clr_i | input | 1 | Restart of the time-base prescaler chain |
| wdt_rst_o | output | 1 | Reset pulse to the processor |

## Verification
The assertions assume inputs are synchronous to the main clock, except the sub clock, which is taken to be slow enough that each of its high and low phases spans at least two main cycles so every rising edge yields one tick. The bench drives all strobes on the falling main edge and derives the sub clock from a divider on that same edge with a six-cycle period. Timeout windows are computed from the tap stage and that period, and clears are placed at random prescaler phases, always earlier than the shortest possible timeout, so each measured delay must land inside its window.

// File: rtl/wdt_tap_pkg.sv
package wdt_tap_pkg;

   // number of selectable taps per prescaler chain
   localparam int unsigned NTAP   = 4;
   localparam int unsigned TSEL_W = $clog2(NTAP);
   localparam int unsigned CFG_W  = TSEL_W + 1;

   // which chain supplies the watchdog carry
   typedef enum logic {
      SRC_SUB  = 1'b0,
      SRC_MAIN = 1'b1
   } wdt_src_e;

   typedef struct packed {
      wdt_src_e            src;
      logic [TSEL_W-1:0]   tap;
   } wdt_cfg_t;

   // value at which the next carry fires the reset
   localparam logic [1:0] CNT_LAST = 2'd3;

endpackage

// File: rtl/wdt_subsync.sv
module wdt_subsync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic async_i,
   output logic rise_o
);

   logic [STAGES-1:0] sync_q;
   logic              last_q;

   initial begin
      assert (STAGES >= 2) else $error("wdt_subsync: STAGES must be at least 2");
   end

   generate
      if (STAGES == 2) begin : g_two
         always_ff @(posedge clk_i) begin
            if (!rst_ni) begin
               sync_q <= '0;
            end else begin
               sync_q <= {sync_q[0], async_i};
            end
         end
      end else begin : g_deep
         always_ff @(posedge clk_i) begin
            if (!rst_ni) begin
               sync_q <= '0;
            end else begin
               sync_q <= {sync_q[STAGES-2:0], async_i};
            end
         end
      end
   endgenerate

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         last_q <= 1'b0;
      end else begin
         last_q <= sync_q[STAGES-1];
      end
   end

   assign rise_o = sync_q[STAGES-1] & ~last_q;

   // a rising edge produces a single-cycle tick (feeds R5)
   p_tick_single_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rise_o |=> !rise_o);

endmodule

// File: rtl/wdt_chain.sv
module wdt_chain
   import wdt_tap_pkg::*;
#(
   parameter int unsigned TAPS [NTAP] = '{1, 2, 3, 4}
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic            tick_i,
   input  logic            clr_i,
   output logic [NTAP-1:0] carry_o
);

   localparam int unsigned W = TAPS[NTAP-1];

   logic [W-1:0] cnt_q;

   initial begin
      assert (TAPS[0] >= 1) else $error("wdt_chain: first tap must be at least 1");
      for (int i = 1; i < NTAP; i++) begin
         assert (TAPS[i] > TAPS[i-1]) else $error("wdt_chain: taps must ascend");
      end
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         cnt_q <= '0;
      end else if (clr_i) begin
         cnt_q <= '0;
      end else if (tick_i) begin
         cnt_q <= cnt_q + W'(1);
      end
   end

   // stage k carries when its low k bits are about to wrap
   generate
      for (genvar i = 0; i < NTAP; i++) begin : g_tap
         assign carry_o[i] = tick_i & ~clr_i & (&cnt_q[TAPS[i]-1:0]);
      end
   endgenerate

   p_clr_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_i |=> cnt_q == '0);

   p_tick_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !clr_i && tick_i |=> cnt_q == $past(cnt_q) + W'(1));

   p_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !clr_i && !tick_i |=> $stable(cnt_q));

endmodule

// File: rtl/wdt_tapmux.sv
module wdt_tapmux
   import wdt_tap_pkg::*;
(
   input  logic [NTAP-1:0] main_carry_i,
   input  logic [NTAP-1:0] sub_carry_i,
   input  wdt_cfg_t        cfg_i,
   output logic            carry_o
);

   always_comb begin
      if (cfg_i.src == SRC_MAIN) begin
         carry_o = main_carry_i[cfg_i.tap];
      end else begin
         carry_o = sub_carry_i[cfg_i.tap];
      end
   end

endmodule

// File: rtl/wdt_core.sv
module wdt_core
   import wdt_tap_pkg::*;
#(
   parameter int unsigned RST_W = 4
) (
   input  logic     clk_i,
   input  logic     rst_ni,
   input  logic     we_i,
   input  wdt_cfg_t wdata_i,
   input  logic     kick_i,
   input  logic     carry_i,
   output wdt_cfg_t cfg_o,
   output logic     rst_o
);

   localparam int unsigned PW = $clog2(RST_W + 1);
   localparam int unsigned HW = $clog2(RST_W + 2);

   logic          active_q;
   wdt_cfg_t      cfg_q;
   logic [1:0]    cnt_q;
   logic [PW-1:0] pls_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         active_q <= 1'b0;
         cfg_q    <= '0;
         cnt_q    <= '0;
         pls_q    <= '0;
      end else begin
         if (pls_q != '0) begin
            pls_q <= pls_q - PW'(1);
         end
         if (!active_q) begin
            if (we_i) begin
               active_q <= 1'b1;
               cfg_q    <= wdata_i;
               cnt_q    <= '0;
            end
         end else if (kick_i) begin
            cnt_q <= '0;
         end else if (carry_i) begin
            if (cnt_q == CNT_LAST) begin
               active_q <= 1'b0;
               cnt_q    <= '0;
               pls_q    <= PW'(RST_W);
            end else begin
               cnt_q <= cnt_q + 2'd1;
            end
         end
      end
   end

   assign cfg_o = cfg_q;
   assign rst_o = (pls_q != '0);

   // run length of the reset pulse, for the width check only
   logic [HW-1:0] hi_run_q;
   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         hi_run_q <= '0;
      end else if (rst_o) begin
         hi_run_q <= hi_run_q + HW'(1);
      end else begin
         hi_run_q <= '0;
      end
   end

   p_idle_zero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !active_q |-> cnt_q == 2'd0);

   p_wr_arms_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !active_q && we_i |=> active_q && cfg_q == $past(wdata_i) && cnt_q == 2'd0);

   p_cfg_locked_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      active_q && $past(active_q) |-> $stable(cfg_q));

   p_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      active_q && !kick_i && carry_i && cnt_q != CNT_LAST |=> cnt_q == $past(cnt_q) + 2'd1);

   p_kick_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      active_q && kick_i |=> active_q && cnt_q == 2'd0);

   p_pulse_len_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(rst_o) |-> hi_run_q == HW'(RST_W));

   p_rise_disarmed_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(rst_o) |-> !active_q);

endmodule

// File: rtl/wdt_tap.sv
module wdt_tap
   import wdt_tap_pkg::*;
#(
   parameter int unsigned MAIN_TAPS [NTAP] = '{12, 14, 16, 19},
   parameter int unsigned SUB_TAPS  [NTAP] = '{10, 13, 14, 15},
   parameter int unsigned RST_W            = 4,
   parameter int unsigned SYNC_STAGES      = 2
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             sclk_i,
   input  logic             cfg_we_i,
   input  logic [CFG_W-1:0] cfg_wdata_i,
   input  logic             kick_i,
   input  logic             tb_clr_i,
   output logic             wdt_rst_o
);

   initial begin
      assert (RST_W >= 1) else $error("wdt_tap: RST_W must be at least 1");
      assert (SYNC_STAGES >= 2) else $error("wdt_tap: SYNC_STAGES must be at least 2");
   end

   logic            sub_tick;
   logic [NTAP-1:0] main_carry;
   logic [NTAP-1:0] sub_carry;
   logic            carry;
   wdt_cfg_t        cfg;

   wdt_subsync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .async_i (sclk_i),
      .rise_o  (sub_tick)
   );

   wdt_chain #(.TAPS(MAIN_TAPS)) u_tb_chain (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .tick_i  (1'b1),
      .clr_i   (tb_clr_i),
      .carry_o (main_carry)
   );

   wdt_chain #(.TAPS(SUB_TAPS)) u_wt_chain (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .tick_i  (sub_tick),
      .clr_i   (1'b0),
      .carry_o (sub_carry)
   );

   wdt_tapmux u_mux (
      .main_carry_i (main_carry),
      .sub_carry_i  (sub_carry),
      .cfg_i        (cfg),
      .carry_o      (carry)
   );

   wdt_core #(.RST_W(RST_W)) u_core (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .we_i    (cfg_we_i),
      .wdata_i (wdt_cfg_t'(cfg_wdata_i)),
      .kick_i  (kick_i),
      .carry_i (carry),
      .cfg_o   (cfg),
      .rst_o   (wdt_rst_o)
   );

   // while the time-base chain is held in restart, the main source cannot fire
   p_tbclr_blocks_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tb_clr_i && cfg.src == SRC_MAIN && !wdt_rst_o |=> !$rose(wdt_rst_o));

endmodule

// File: tb/sim_wdt_tap.sv
`timescale 1ns/1ps
module sim_wdt_tap;

   localparam int unsigned MT [4] = '{2, 3, 4, 5};
   localparam int unsigned ST [4] = '{1, 2, 3, 4};
   localparam int unsigned RW = 3;
   localparam int SH = 3;
   localparam int SP = 2 * SH;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sclk = 1'b0;
   logic       we = 1'b0;
   logic [2:0] wd = '0;
   logic       kick = 1'b0;
   logic       tbc = 1'b0;
   logic       rst_o;

   int errors = 0;
   int checks = 0;
   int hi_cycles = 0;
   int sdiv = 0;
   bit done = 1'b0;

   wdt_tap #(.MAIN_TAPS(MT), .SUB_TAPS(ST), .RST_W(RW), .SYNC_STAGES(2)) u0 (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .sclk_i      (sclk),
      .cfg_we_i    (we),
      .cfg_wdata_i (wd),
      .kick_i      (kick),
      .tb_clr_i    (tbc),
      .wdt_rst_o   (rst_o)
   );

   always #2.5 clk = ~clk;

   always @(negedge clk) begin
      if (sdiv == SH - 1) begin
         sdiv <= 0;
         sclk <= ~sclk;
      end else begin
         sdiv <= sdiv + 1;
      end
      if (rst_o === 1'b1) hi_cycles <= hi_cycles + 1;
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input bit src, input int tap);
      @(negedge clk);
      we = 1'b1;
      wd = {src, 2'(tap)};
      @(negedge clk);
      we = 1'b0;
   endtask

   task automatic kk();
      @(negedge clk);
      kick = 1'b1;
      @(negedge clk);
      kick = 1'b0;
   endtask

   // cycles from the last strobe edge to the pulse, then pulse width
   task automatic wait_rst(input int limit, output int d, output int w);
      d = 0;
      w = 0;
      while (d < limit) begin
         @(posedge clk);
         d++;
         @(negedge clk);
         if (rst_o) break;
      end
      if (!rst_o) d = limit + 1;
      while (rst_o) begin
         w++;
         @(negedge clk);
      end
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      #(150000 * 5);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
         finish_run();
      end
   end

   initial begin
      int d, w, base;
      cyc(5);
      rst_n = 1'b1;
      cyc(2);

      // R1: disarmed after reset, clears ignored
      chk(rst_o == 1'b0, "R1", "reset state", int'(rst_o), 0);
      base = hi_cycles;
      kk();
      cyc(500);
      chk(hi_cycles == base, "R1", "pulse while disarmed", hi_cycles - base, 0);

      // R2: window counted from the arming write (main tap 0, k=2)
      wr(1'b1, 0);
      wait_rst(26, d, w);
      chk(d >= 13 && d <= 16, "R2", "delay from arming write", d, 13);

      // R4 / R5 / R8: sweep sources, taps and clear phases
      for (int src = 0; src < 2; src++) begin
         for (int tap = 0; tap < 4; tap++) begin
            for (int tr = 0; tr < 6; tr++) begin
               int k, sc, t, lo, hi, r;
               k  = src ? int'(MT[tap]) : int'(ST[tap]);
               sc = src ? 1 : SP;
               t  = 1 << k;
               lo = 3 * t * sc + 1;
               hi = 4 * t * sc;
               cyc($urandom_range(0, 37));
               wr(src[0], tap);
               r = $urandom_range(0, 3 * t * sc - 2);
               cyc(r);
               kk();
               wait_rst(hi + 10, d, w);
               chk(d >= lo && d <= hi, src ? "R4" : "R5", "timeout window", d, lo);
               chk(w == RW, "R8", "pulse width", w, RW);
            end
         end
      end

      // R3: second write while armed must not shorten the interval
      wr(1'b1, 3);
      cyc(5);
      wr(1'b1, 0);
      kk();
      wait_rst(140, d, w);
      chk(d >= 97 && d <= 128, "R3", "locked configuration", d, 97);

      // R6: regular clears keep it quiet (main tap 1, window 25..32)
      wr(1'b1, 1);
      base = hi_cycles;
      for (int i = 0; i < 15; i++) begin
         cyc(18);
         kk();
      end
      chk(hi_cycles == base, "R6", "pulse despite clears", hi_cycles - base, 0);
      wait_rst(42, d, w);
      chk(d >= 25 && d <= 32, "R6", "timeout after last clear", d, 25);

      // R7: restarting the time-base chain stretches the timeout (tap 0, k=2)
      wr(1'b1, 0);
      base = hi_cycles;
      for (int i = 0; i < 60; i++) begin
         cyc(1);
         @(negedge clk);
         tbc = 1'b1;
         @(negedge clk);
         tbc = 1'b0;
      end
      chk(hi_cycles == base, "R7", "pulse during chain restarts", hi_cycles - base, 0);
      wait_rst(26, d, w);
      chk(d >= 12 && d <= 16, "R7", "timeout after last restart", d, 12);

      // R9: disarmed after the pulse, clears ignored
      base = hi_cycles;
      kk();
      cyc(500);
      chk(hi_cycles == base, "R9", "pulse after firing", hi_cycles - base, 0);
      wr(1'b0, 0);
      wait_rst(4 * 2 * SP + 10, d, w);
      chk(d >= 3 * 2 * SP + 1 && d <= 4 * 2 * SP, "R9", "rearm by write", d, 3 * 2 * SP + 1);

      done = 1'b1;
      finish_run();
   end

endmodule